// File: doc/BRIEF.md
# Unanimous-Tap Clock Glitch Filter

This block cleans up a clock or strobe that arrives on a pin with slow edges and a noisy input stage. While such a signal crosses the switching threshold it can chatter, and each extra transition would be a false clock edge further on. The filter oversamples the pin on a fast sampling clock and synchronizes it. It then shifts the samples through a chain of taps that act as an observation window. A set/reset style output register goes high only when every tap reads 1 and low only when every tap reads 0. In every other case it keeps its value, so each real edge of the input gives exactly one output edge.

The window length is the tap count times the sampling period. It must be longer than the time the input can spend dithering near its threshold. A clean input edge reaches the output after a fixed latency set by the synchronizer depth and the tap count.

Top module: `clk_glitch_filter`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, the synchronizer, the whole tap window and `clean_out` are cleared to 0.
- R2: `clean_out` becomes 1 on the edge after every one of the TAP_COUNT taps holds a 1 sample.
- R3: `clean_out` becomes 0 on the edge after every one of the TAP_COUNT taps holds a 0 sample.
- R4: When the taps hold a mix of 0 and 1 samples, `clean_out` keeps its previous value.
- R5: The raw input passes through SYNC_STAGES synchronizer flops before it enters the tap window. A clean edge on `raw_in` therefore appears on `clean_out` at the (SYNC_STAGES + TAP_COUNT + 1)-th rising edge after the change, which is the 11th edge with the defaults (2, 8).
- R6: A burst of alternating samples, or any run of opposite samples shorter than TAP_COUNT, produces no change on `clean_out`.
- R7: An input edge that chatters for fewer than TAP_COUNT samples before it settles produces exactly one transition of `clean_out`.
- R8: The tap window is a shift register: each clock, every tap takes the previous value of the tap before it, and the first tap takes the synchronizer output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| raw_in | input | 1 | Unfiltered clock or strobe from the pin, asynchronous to `clk` |
| clean_out | output | 1 | Filtered signal, one transition per input edge |

## Verification
The bench aims at runs of samples that stop just short of agreement. If seven ones are followed by a zero, a filter that counted ones instead of requiring unanimity, or that tested one tap too few, would toggle falsely. The bench also sends alternating bursts and an edge that chatters before it settles. A design without hold behaviour would then give several output edges where one is expected. The edge latency is measured in clocks to catch a missing or extra register stage, and the falling edge is checked separately from the rising one so that a wrong clear test shows up.

// File: rtl/glitch_filter_pkg.sv
// Package: shared decision type for the glitch filter.
// Assumes nothing beyond IEEE 1800-2017 enums.
package glitch_filter_pkg;

    // Outcome of the unanimous vote over the tap window.
    typedef enum logic [1:0] {
        VOTE_HOLD  = 2'b00,
        VOTE_SET   = 2'b01,
        VOTE_CLEAR = 2'b10
    } vote_e;

endpackage

// File: rtl/gf_sync.sv
// Module: gf_sync
// Brings the asynchronous raw input into the clk domain through a chain of
// DEPTH flops. Assumes DEPTH >= 2. Synchronous active-low reset clears it to 0.
module gf_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [DEPTH-1:0] stage_q;

    // Shift the raw level through the synchronizer flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[DEPTH-2:0], async_in};
        end
    end

    assign sync_out = stage_q[DEPTH-1];

endmodule

// File: rtl/gf_tap_chain.sv
// Module: gf_tap_chain
// Holds the last TAPS synchronized samples. Bit 0 is the newest sample.
// Assumes TAPS >= 2. Every tap is visible on the output.
module gf_tap_chain #(
    parameter int TAPS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample_in,
    output logic [TAPS-1:0] taps
);

    logic [TAPS-1:0] tap_q;

    // Advance the observation window by one sample each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q <= '0;
        end else begin
            tap_q <= {tap_q[TAPS-2:0], sample_in};
        end
    end

    assign taps = tap_q;

endmodule

// File: rtl/gf_vote.sv
// Module: gf_vote
// Combinational unanimous vote: SET when all taps are 1, CLEAR when all taps
// are 0, HOLD otherwise. Assumes TAPS >= 2, so SET and CLEAR never coincide.
module gf_vote
    import glitch_filter_pkg::*;
#(
    parameter int TAPS = 8
) (
    input  logic [TAPS-1:0] taps,
    output vote_e           vote
);

    logic all_high;
    logic all_low;

    // Reduction tests over the whole window.
    always_comb begin
        all_high = &taps;
        all_low  = ~|taps;
        if (all_high) begin
            vote = VOTE_SET;
        end else if (all_low) begin
            vote = VOTE_CLEAR;
        end else begin
            vote = VOTE_HOLD;
        end
    end

endmodule

// File: rtl/gf_sr_reg.sv
// Module: gf_sr_reg
// Clocked set/reset output register driven by the vote. It keeps its value
// on HOLD. Reset drives it to 0.
module gf_sr_reg
    import glitch_filter_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  vote_e vote,
    output logic  q
);

    logic q_r;

    // Apply set, clear or hold to the output state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= 1'b0;
        end else begin
            case (vote)
                VOTE_SET:   q_r <= 1'b1;
                VOTE_CLEAR: q_r <= 1'b0;
                default:    q_r <= q_r;
            endcase
        end
    end

    assign q = q_r;

endmodule

// File: rtl/clk_glitch_filter.sv
// Module: clk_glitch_filter (top)
// Glitch filter for a slow-edged clock or strobe. The pin is synchronized,
// shifted through a TAP_COUNT-deep window, and a set/reset output changes
// only when the whole window agrees. Assumes the clk period times TAP_COUNT
// exceeds the input's dwell time at its threshold.
module clk_glitch_filter
    import glitch_filter_pkg::*;
#(
    parameter int TAP_COUNT   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic clean_out
);

    localparam int LATENCY = SYNC_STAGES + TAP_COUNT + 1;

    logic                 sync_bit;
    logic [TAP_COUNT-1:0] tap_vec;
    vote_e                vote_w;

    gf_sync #(.DEPTH(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (sync_bit)
    );

    gf_tap_chain #(.TAPS(TAP_COUNT)) u_taps (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_in (sync_bit),
        .taps      (tap_vec)
    );

    gf_vote #(.TAPS(TAP_COUNT)) u_vote (
        .taps (tap_vec),
        .vote (vote_w)
    );

    gf_sr_reg u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .vote  (vote_w),
        .q     (clean_out)
    );

endmodule

// File: rtl/clk_glitch_filter_chk.sv
// Module: clk_glitch_filter_chk
// Checker bound to clk_glitch_filter. It watches the synchronizer output,
// the tap window and the filtered output.
module clk_glitch_filter_chk #(
    parameter int TAP_COUNT = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sync_bit,
    input logic [TAP_COUNT-1:0] tap_vec,
    input logic                 clean_out
);

    // R2: a unanimous window of ones sets the output.
    a_r2_set_on_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (&tap_vec) |=> clean_out);

    // R3: a unanimous window of zeros clears the output.
    a_r3_clear_on_all_zeros: assert property (@(posedge clk) disable iff (!rst_n)
        (~|tap_vec) |=> !clean_out);

    // R4: a mixed window leaves the output unchanged.
    a_r4_hold_on_mixed: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&tap_vec) && (|tap_vec)) |=> $stable(clean_out));

    // R8: the first tap takes the synchronizer output.
    a_r8_first_tap: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tap_vec[0] == $past(sync_bit)));

    // R8: the window shifts by one tap per clock.
    a_r8_window_shift: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tap_vec[TAP_COUNT-1:1] == $past(tap_vec[TAP_COUNT-2:0])));

endmodule

bind clk_glitch_filter clk_glitch_filter_chk #(.TAP_COUNT(TAP_COUNT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_bit  (sync_bit),
    .tap_vec   (tap_vec),
    .clean_out (clean_out)
);

// File: tb/test_clk_glitch_filter.sv
module test_clk_glitch_filter;

    localparam int CLK_PERIOD = 10;
    localparam int TAPS       = 8;
    localparam int SYNC       = 2;
    localparam int LAT        = SYNC + TAPS + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic raw_in = 1'b0;
    logic clean_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    clk_glitch_filter #(.TAP_COUNT(TAPS), .SYNC_STAGES(SYNC)) i_clk_glitch_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_in    (raw_in),
        .clean_out (clean_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: history of input samples, newest first.
    bit hist[$];
    bit exp_out = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i < SYNC + TAPS + 2; i++) hist.push_back(1'b0);
            exp_out <= 1'b0;
        end else begin
            int ones;
            hist.push_front(raw_in);
            void'(hist.pop_back());
            ones = 0;
            for (int k = SYNC + 1; k <= SYNC + TAPS; k++) ones += hist[k];
            if (ones == TAPS) exp_out <= 1'b1;
            else if (ones == 0) exp_out <= 1'b0;
        end
    end

    // Every-clock comparison against the model (R2 R3 R4 R1).
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (clean_out !== exp_out) begin
                errors++;
                $display("FAIL R2/R3/R4 model compare t=%0t: actual %b expected %b",
                         $time, clean_out, exp_out);
            end
        end
    end

    task automatic check(input string req, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, expv);
        end
    endtask

    // Drive one sample value for one clock, changing at the falling edge.
    task automatic drive(input logic v);
        raw_in = v;
        @(negedge clk);
    endtask

    task automatic hold(input logic v, input int n);
        for (int i = 0; i < n; i++) drive(v);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int edges;
        int toggles;
        logic prev;
        @(negedge clk);
        raw_in = 1'b1;
        hold(1'b1, 4);
        // R1: the output stays 0 under reset even with the input high.
        check("R1 reset output", clean_out, 1'b0);
        raw_in = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        hold(1'b0, 20);
        check("R1 after reset", clean_out, 1'b0);

        // R5: rising edge latency.
        raw_in = 1'b1;
        edges = 0;
        while (clean_out == 1'b0 && edges < 40) begin
            @(negedge clk);
            edges++;
        end
        checks++;
        if (edges != LAT) begin
            errors++;
            $display("FAIL R5 rise latency: actual %0d expected %0d", edges, LAT);
        end
        check("R2 set after ones", clean_out, 1'b1);
        hold(1'b1, 5);

        // R5 and R3: falling edge latency.
        raw_in = 1'b0;
        edges = 0;
        while (clean_out == 1'b1 && edges < 40) begin
            @(negedge clk);
            edges++;
        end
        checks++;
        if (edges != LAT) begin
            errors++;
            $display("FAIL R5 fall latency: actual %0d expected %0d", edges, LAT);
        end
        check("R3 clear after zeros", clean_out, 1'b0);
        hold(1'b0, 15);

        // R6: a run of TAPS-1 ones must not set the output.
        hold(1'b1, TAPS - 1);
        hold(1'b0, 20);
        check("R6 short high run ignored", clean_out, 1'b0);

        // R6: alternating burst while low.
        for (int i = 0; i < 12; i++) drive(i[0]);
        hold(1'b0, 20);
        check("R6 alternating burst low", clean_out, 1'b0);

        // Bring output high, then a short low run and an alternating burst.
        hold(1'b1, 20);
        check("R2 high again", clean_out, 1'b1);
        hold(1'b0, TAPS - 1);
        hold(1'b1, 20);
        check("R6 short low run ignored", clean_out, 1'b1);
        for (int i = 0; i < 12; i++) drive(~i[0]);
        hold(1'b1, 20);
        check("R4 R6 alternating burst high", clean_out, 1'b1);

        // R7: a chattering falling edge gives exactly one transition.
        toggles = 0;
        prev = clean_out;
        for (int i = 0; i < 7; i++) begin
            drive(i[0]);
            if (clean_out != prev) toggles++;
            prev = clean_out;
        end
        for (int i = 0; i < 25; i++) begin
            drive(1'b0);
            if (clean_out != prev) toggles++;
            prev = clean_out;
        end
        checks++;
        if (toggles != 1) begin
            errors++;
            $display("FAIL R7 chatter fall toggles: actual %0d expected 1", toggles);
        end
        check("R7 settled low", clean_out, 1'b0);

        // R7: a chattering rising edge gives exactly one transition.
        toggles = 0;
        for (int i = 0; i < 7; i++) begin
            drive(~i[0]);
            if (clean_out != prev) toggles++;
            prev = clean_out;
        end
        for (int i = 0; i < 25; i++) begin
            drive(1'b1);
            if (clean_out != prev) toggles++;
            prev = clean_out;
        end
        checks++;
        if (toggles != 1) begin
            errors++;
            $display("FAIL R7 chatter rise toggles: actual %0d expected 1", toggles);
        end
        check("R7 settled high", clean_out, 1'b1);

        // R1 and R8: a reset mid-run clears everything; ones then need the full window.
        rst_n = 1'b0;
        hold(1'b1, 2);
        check("R1 mid-run reset", clean_out, 1'b0);
        rst_n = 1'b1;
        hold(1'b1, LAT - 1);
        check("R8 window refills after reset", clean_out, 1'b0);
        hold(1'b1, 1);
        check("R8 set after full window", clean_out, 1'b1);
        hold(1'b1, 4);

        finish_run();
    end

endmodule